// File: doc/BRIEF.md
# Paged Monochrome LCD Controller

This block sits on a processor's register bus and keeps the picture for a 128 by 64 one-bit display. Software picks a transfer mode, chooses one of eight horizontal bands of eight rows (a "page"), and then streams bytes that land in consecutive columns of that page. Each byte covers eight vertically stacked pixels of one column.

A separate scan port lets display refresh logic fetch any single pixel by its x and y coordinates without disturbing bus traffic. The block also turns an encoded backlight word into a brightness step from 0 to 7 and a scaled intensity value.

Top module: `lcd_page_ctrl`

## Requirements
- R1: After reset the transfer mode is off (data writes are dropped), the page and the column are 0, and the interrupt control and status registers read 0.
- R2: A write to the mode register (offset 0x1AC) selects data mode only for 0x00100011 and command mode only for 0x00104011; any other value turns the mode off, and in that mode writes to the data register (offset 0x1C0) change neither the memory nor the column.
- R3: Writing a value from 0xB0 to 0xB7 to the instruction register (offset 0x1BC) selects page value minus 0xB0 and sets the column to 0; other instruction values change nothing.
- R4: In command mode a data register write of 0xB0 to 0xB7 selects a page exactly as in R3; any other data value in command mode is dropped without storing or moving the column.
- R5: In data mode a data register write stores its low byte at address page*128 + column and advances the column by one, wrapping from 127 to 0 within the same page.
- R6: The scan port returns pixel (x, y) as bit (y mod 8) of byte x + (y div 8)*128, on scan_pix one clock after scan_x and scan_y are sampled.
- R7: The backlight codes 0x00000007, 0x00020000, 0x00020001, 0x00040000, 0x00010006, 0x00020005, 0x00040003, 0x00030004 give levels 0 to 7 in that order, any other code gives level 7, and the intensity is floor(255 * level / 7).
- R8: The interrupt control (offset 0x180) and interrupt status (offset 0x184) registers read back the last value written; every other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| scan_x | input | 7 | Pixel column to fetch |
| scan_y | input | 6 | Pixel row to fetch |
| scan_pix | output | 1 | Fetched pixel, one clock later |
| bl_code | input | 32 | Encoded backlight word |
| bl_level | output | 3 | Brightness step 0 to 7 |
| bl_intensity | output | 8 | Scaled intensity |

## Verification
The bench targets column wrap at 127, where a design that spills into the next page would corrupt column 0 of the following band, and page selection issued as data in command mode, where a design that stores the byte instead would shift every later byte by one column. It also writes illegal mode values and page codes just outside 0xB0 to 0xB7; a design accepting them would move the write pointer and the scan would show bytes at the wrong place. A reset in the middle of a stream checks that page, column and mode all return to their idle values, and every backlight code plus unknown ones are compared against the expected step and intensity.

// File: rtl/lcd_page_ctrl.sv
module lcd_page_ctrl #(
  parameter int COLS   = 128,
  parameter int PAGES  = 8,
  parameter int INT_W  = 8,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [$clog2(COLS)-1:0]    scan_x,
  input  logic [$clog2(PAGES)+2:0]   scan_y,
  output logic              scan_pix,
  input  logic [31:0]       bl_code,
  output logic [2:0]        bl_level,
  output logic [INT_W-1:0]  bl_intensity
);
  localparam int COL_W = $clog2(COLS);
  localparam int PG_W  = $clog2(PAGES);
  localparam int MEM_N = COLS * PAGES;
  localparam int FULL  = (1 << INT_W) - 1;
  localparam logic [ADDR_W-1:0] OFS_IRQ_CTL = ADDR_W'('h180);
  localparam logic [ADDR_W-1:0] OFS_IRQ_STA = ADDR_W'('h184);
  localparam logic [ADDR_W-1:0] OFS_MODE    = ADDR_W'('h1AC);
  localparam logic [ADDR_W-1:0] OFS_INST    = ADDR_W'('h1BC);
  localparam logic [ADDR_W-1:0] OFS_DATA    = ADDR_W'('h1C0);
  localparam logic [31:0] KEY_DATA = 32'h0010_0011;
  localparam logic [31:0] KEY_CMD  = 32'h0010_4011;
  localparam logic [31:0] PG_BASE  = 32'h0000_00B0;

  typedef enum logic [1:0] {M_OFF, M_DATA, M_CMD} mode_t;

  mode_t             mode;
  logic [PG_W-1:0]   page;
  logic [COL_W-1:0]  col;
  logic [31:0]       irq_ctl, irq_sta;
  logic [7:0]        vram [MEM_N];

  wire wr_mode  = bus_wr && bus_addr == OFS_MODE;
  wire wr_inst  = bus_wr && bus_addr == OFS_INST;
  wire wr_data  = bus_wr && bus_addr == OFS_DATA;
  wire pg_hit   = bus_wdata >= PG_BASE && bus_wdata < PG_BASE + PAGES;
  wire pg_sel   = (wr_inst || (wr_data && mode == M_CMD)) && pg_hit;
  wire px_store = wr_data && mode == M_DATA;
  wire [PG_W-1:0] pg_new = PG_W'(bus_wdata - PG_BASE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode    <= M_OFF;
      page    <= '0;
      col     <= '0;
      irq_ctl <= '0;
      irq_sta <= '0;
    end else begin
      if (wr_mode)
        mode <= (bus_wdata == KEY_DATA) ? M_DATA :
                (bus_wdata == KEY_CMD)  ? M_CMD  : M_OFF;
      if (bus_wr && bus_addr == OFS_IRQ_CTL) irq_ctl <= bus_wdata;
      if (bus_wr && bus_addr == OFS_IRQ_STA) irq_sta <= bus_wdata;
      if (pg_sel) begin
        page <= pg_new;
        col  <= '0;
      end else if (px_store) begin
        col <= (col == COL_W'(COLS - 1)) ? '0 : col + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (px_store) vram[{page, col}] <= bus_wdata[7:0];
    scan_pix <= vram[{scan_y[PG_W+2:3], scan_x}][scan_y[2:0]];
  end

  always_comb begin
    case (bus_addr)
      OFS_IRQ_CTL: bus_rdata = irq_ctl;
      OFS_IRQ_STA: bus_rdata = irq_sta;
      default:     bus_rdata = '0;
    endcase
  end

  always_comb begin
    case (bl_code)
      32'h0000_0007: bl_level = 3'd0;
      32'h0002_0000: bl_level = 3'd1;
      32'h0002_0001: bl_level = 3'd2;
      32'h0004_0000: bl_level = 3'd3;
      32'h0001_0006: bl_level = 3'd4;
      32'h0002_0005: bl_level = 3'd5;
      32'h0004_0003: bl_level = 3'd6;
      default:       bl_level = 3'd7;
    endcase
  end

  wire [31:0] bl_prod = 32'(FULL) * {29'd0, bl_level};
  assign bl_intensity = INT_W'(bl_prod / 32'd7);

  a_r1_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(page) && $stable(col) && $stable(mode));

  a_r2_off_drops_data: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF && wr_data) |=> $stable(col) && $stable(page));

  a_r3_page_pick: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_inst && pg_hit) |=> col == '0 && page == $past(bus_wdata[PG_W-1:0]));

  a_r5_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (px_store && $past(col) != col && col != '0) |->
      col == $past(col) + 1'b1);

  a_r5_wrap_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (px_store && col == COL_W'(COLS - 1)) |=> col == '0 && $stable(page));

  a_r7_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (bl_level == 3'd0 |-> bl_intensity == '0) and
    (bl_level == 3'd7 |-> bl_intensity == INT_W'(FULL)));
endmodule

// File: tb/tb_lcd_page_ctrl.sv
module tb_lcd_page_ctrl;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_wr = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [6:0]  scan_x = '0;
  logic [5:0]  scan_y = '0;
  logic        scan_pix;
  logic [31:0] bl_code = '0;
  logic [2:0]  bl_level;
  logic [7:0]  bl_intensity;

  lcd_page_ctrl dut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  logic [7:0] sh [1024];
  int  m_mode = 0;
  int  m_page = 0, m_col = 0;
  bit    exp_q [$];
  string tag_q [$];
  int    xy_q [$];

  localparam logic [31:0] KD = 32'h0010_0011, KC = 32'h0010_4011;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
    if (a == 12'h1AC) m_mode = (d == KD) ? 1 : (d == KC) ? 2 : 0;
    else if (a == 12'h1BC || (a == 12'h1C0 && m_mode == 2)) begin
      if (d >= 32'hB0 && d <= 32'hB7) begin m_page = int'(d - 32'hB0); m_col = 0; end
    end else if (a == 12'h1C0 && m_mode == 1) begin
      sh[m_page*128 + m_col] = d[7:0];
      m_col = (m_col + 1) % 128;
    end
  endtask

  task automatic scan(input int x, input int y, input string req);
    @(negedge clk);
    scan_x = 7'(x); scan_y = 6'(y);
    exp_q.push_back(sh[x + (y/8)*128][y%8]);
    tag_q.push_back(req);
    xy_q.push_back(x*256 + y);
  endtask

  task automatic scan_byte(input int pg, input int c, input string req);
    for (int b = 0; b < 8; b++) scan(c, pg*8 + b, req);
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #2;
    if (exp_q.size() != 0) begin
      bit e; string t; int xy;
      e = exp_q.pop_front(); t = tag_q.pop_front(); xy = xy_q.pop_front();
      check(scan_pix === e, $sformatf("%s pixel x=%0d y=%0d", t, xy/256, xy%256),
            int'(scan_pix), int'(e));
    end
  end

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string req);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(bus_rdata === e, req, int'(bus_rdata), int'(e));
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk); rst_n = 1;
    m_mode = 0; m_page = 0; m_col = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] codes [8];
    int          ints [8];
    codes = '{32'h7, 32'h20000, 32'h20001, 32'h40000, 32'h10006, 32'h20005, 32'h40003, 32'h30004};
    ints  = '{0, 36, 72, 109, 145, 182, 218, 255};
    do_reset();
    rd(12'h180, 0, "R1 irq control after reset");
    rd(12'h184, 0, "R1 irq status after reset");

    wr(12'h1AC, KD);
    for (int p = 0; p < 8; p++) begin
      wr(12'h1BC, 32'hB0 + p);
      for (int c = 0; c < 128; c++) wr(12'h1C0, 0);
    end

    // R1: move pointer, reset, then data writes in off mode are dropped
    wr(12'h1BC, 32'hB5); wr(12'h1C0, 8'h0F);
    do_reset();
    wr(12'h1C0, 8'hFF);
    wr(12'h1AC, KD);
    wr(12'h1C0, 8'h3C);
    scan_byte(0, 0, "R1");
    scan_byte(0, 1, "R1");
    scan_byte(5, 0, "R1");
    drain();

    // R8 readback
    wr(12'h180, 32'h1234_5678);
    wr(12'h184, 32'hCAFE_F00D);
    rd(12'h180, 32'h1234_5678, "R8 irq control");
    rd(12'h184, 32'hCAFE_F00D, "R8 irq status");
    rd(12'h1C0, 0, "R8 other offset");

    // R3 page select and ignored codes
    wr(12'h1BC, 32'hB3); wr(12'h1C0, 8'h81); wr(12'h1C0, 8'h42);
    wr(12'h1BC, 32'hB8); wr(12'h1BC, 32'hAF); wr(12'h1BC, 32'h1B3);
    wr(12'h1C0, 8'hE7);
    scan_byte(3, 0, "R3"); scan_byte(3, 1, "R3"); scan_byte(3, 2, "R3");
    scan_byte(0, 2, "R3");
    drain();

    // R5 wrap within page
    wr(12'h1BC, 32'hB6);
    for (int c = 0; c < 129; c++) wr(12'h1C0, 32'(c * 7 + 1));
    scan_byte(6, 0, "R5"); scan_byte(6, 127, "R5"); scan_byte(6, 64, "R5");
    scan_byte(7, 0, "R5"); scan_byte(6, 1, "R5");
    drain();

    // R4 command mode
    wr(12'h1AC, KC);
    wr(12'h1C0, 32'hB2);
    wr(12'h1C0, 8'h55);
    wr(12'h1AC, KD);
    wr(12'h1C0, 8'h99);
    scan_byte(2, 0, "R4"); scan_byte(2, 1, "R4");
    drain();

    // R2 illegal mode value
    wr(12'h1AC, 32'h0010_0010);
    wr(12'h1C0, 8'h77);
    wr(12'h1AC, 32'h0010_4010);
    wr(12'h1C0, 8'hB4);
    wr(12'h1AC, KD);
    wr(12'h1C0, 8'h11);
    scan_byte(2, 1, "R2"); scan_byte(2, 2, "R2"); scan_byte(4, 0, "R2");
    drain();

    // R6 scattered pixels
    scan(0, 0, "R6"); scan(127, 63, "R6"); scan(5, 23, "R6"); scan(64, 48, "R6");
    scan(1, 52, "R6"); scan(127, 55, "R6");
    drain();

    // R7 backlight
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); bl_code = codes[i]; #1;
      check(bl_level == 3'(i), "R7 level", int'(bl_level), i);
      check(bl_intensity == 8'(ints[i]), "R7 intensity", int'(bl_intensity), ints[i]);
    end
    @(negedge clk); bl_code = 32'h0; #1;
    check(bl_level == 3'd7 && bl_intensity == 8'd255, "R7 unknown code", int'(bl_intensity), 255);
    @(negedge clk); bl_code = 32'hFFFF_FFFF; #1;
    check(bl_level == 3'd7 && bl_intensity == 8'd255, "R7 unknown code", int'(bl_intensity), 255);

    drain();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule